// File: doc/BRIEF.md
# Clock Mode Controller With Lock Timer

This block turns a small set of clock configuration bits into the enables that steer a clock generator: the on-chip oscillator, the oscillator's output buffer, the reference multiplier (with its power-down) and the gate in front of the system clock. Software stages a new configuration on the `cfg_*` inputs and commits it with a one-cycle `cfg_apply` strobe. From then on, the committed configuration and the live mode-select pin set the enables.

The multiplier field is five bits wide. Any value from 4 to 20 turns the multiplier on with that integer factor. Any other value bypasses the multiplier and powers it down, and the block then reports a factor of 1. A commit that moves the multiplier to a new enabled factor starts a lock timer of `LOCK_CYCLES` cycles, which stands for about one millisecond. `clk_valid` is held low until that timer runs out. A commit that selects bypass makes the clock valid on the next cycle, with no wait.

A three-state machine tracks validity:
- **ST_UNSET** is the state after reset.
- **ST_LOCKING** is the state while the timer counts.
- **ST_VALID** is the state once the clock can be used.

Its transitions are:
- **T_START**: from ST_UNSET or ST_VALID to ST_LOCKING, on a commit that changes the enabled factor.
- **T_SETTLE**: from ST_UNSET or ST_VALID to ST_VALID, on any other commit.
- **T_RELOAD**: from ST_LOCKING to ST_LOCKING, on a commit with a new enabled factor. The timer restarts.
- **T_ABORT**: from ST_LOCKING to ST_VALID, on a commit that selects bypass.
- **T_EXPIRE**: from ST_LOCKING to ST_VALID, when the timer reaches zero.

Top module: `clk_mode_ctrl`

## Requirements
- R1: After reset, and until the first commit, the outputs are: `clk_valid`=0, `mult_bypass`=1, `pll_pwrdn`=1, `pll_en`=0, `mult_factor`=1, `sysclk_en`=1 and `osc_buf_en`=0.
- R2: The `cfg_*` inputs have no effect unless `cfg_apply` is 1 at a clock edge. Without a commit, `mult_factor` and `sysclk_en` do not change.
- R3: A committed `cfg_mult` value from 4 to 20 (unsigned decimal) gives `pll_en`=1, `pll_pwrdn`=0 and `mult_bypass`=0, with `mult_factor` equal to that value.
- R4: A committed `cfg_mult` value of 0–3 or 21–31 gives `pll_en`=0, `pll_pwrdn`=1, `mult_bypass`=1 and `mult_factor`=1.
- R5: `osc_en` follows `mode_sel_pin` directly. `osc_buf_en` is 1 only while `mode_sel_pin` is 1 and the committed `cfg_xo_buf` bit is 1. When the pin is low, both are 0.
- R6: A committed `cfg_clk_off`=1 drives `sysclk_en` to 0 and `clk_valid` to 0. It leaves `osc_en` unchanged.
- R7: A commit that moves the multiplier to a different enabled factor (including a move from bypass) holds `clk_valid` low for exactly `LOCK_CYCLES` cycles after the commit edge. `clk_valid` then rises.
- R8: Committing the factor that is already enabled does not restart the timer. From ST_VALID, `clk_valid` stays 1. From ST_LOCKING, the original expiry time is kept.
- R9: A commit that selects bypass raises `clk_valid` on the cycle after the commit edge (when the clock is not gated off), even if a lock wait was running.
- R10: When a commit with a new enabled factor falls on the same edge at which the timer would expire, the restart wins and `clk_valid` stays low for another `LOCK_CYCLES` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sel_pin | input | 1 | Live mode-select pin; high enables the on-chip oscillator |
| cfg_apply | input | 1 | One-cycle commit strobe for the staged configuration |
| cfg_clk_off | input | 1 | Staged system-clock disable bit |
| cfg_mult | input | 5 | Staged multiplier field |
| cfg_xo_buf | input | 1 | Staged oscillator output-buffer enable bit |
| osc_en | output | 1 | Oscillator enable |
| osc_buf_en | output | 1 | Oscillator output-buffer enable |
| sysclk_en | output | 1 | System clock gate enable |
| pll_en | output | 1 | Multiplier enable |
| pll_pwrdn | output | 1 | Multiplier power-down |
| mult_bypass | output | 1 | Multiplier is bypassed |
| mult_factor | output | 5 | Effective multiplication factor |
| clk_valid | output | 1 | Clock may be used |

## Verification
The timer's expiry and a fresh commit of a new enabled factor can land on the same clock edge. The machine must then either leave ST_LOCKING or reload the timer. The bench provokes this case by counting cycles from one commit and placing a second commit with a different factor exactly on the expiry edge. It then requires `clk_valid` to stay low for a further full `LOCK_CYCLES` cycles, rather than rising in between.

// File: rtl/clkm_pkg.sv
package clkm_pkg;

    parameter int MULT_W = 5;

    typedef enum logic [1:0] {
        ST_UNSET   = 2'd0,
        ST_LOCKING = 2'd1,
        ST_VALID   = 2'd2
    } lock_state_e;

    function automatic logic mult_in_range(input logic [MULT_W-1:0] v,
                                           input int lo, input int hi);
        return (int'(v) >= lo) && (int'(v) <= hi);
    endfunction

endpackage

// File: rtl/clkm_cfg_regs.sv
module clkm_cfg_regs
    import clkm_pkg::*;
#(
    parameter int MULT_MIN = 4,
    parameter int MULT_MAX = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              apply,
    input  logic              clk_off_in,
    input  logic [MULT_W-1:0] mult_in,
    input  logic              xo_buf_in,
    output logic              clk_off_q,
    output logic [MULT_W-1:0] mult_q,
    output logic              xo_buf_q,
    output logic              restart_req,
    output logic              bypass_req
);

    logic new_enabled;
    logic cur_enabled;

    always_comb begin
        new_enabled = mult_in_range(mult_in, MULT_MIN, MULT_MAX);
        cur_enabled = mult_in_range(mult_q, MULT_MIN, MULT_MAX);
        restart_req = apply && new_enabled && (!cur_enabled || (mult_in != mult_q));
        bypass_req  = apply && !new_enabled;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_off_q <= 1'b0;
            mult_q    <= '0;
            xo_buf_q  <= 1'b0;
        end else if (apply) begin
            clk_off_q <= clk_off_in;
            mult_q    <= mult_in;
            xo_buf_q  <= xo_buf_in;
        end
    end

endmodule

// File: rtl/clkm_decode.sv
module clkm_decode
    import clkm_pkg::*;
#(
    parameter int MULT_MIN = 4,
    parameter int MULT_MAX = 20
) (
    input  logic              pin_sel,
    input  logic              clk_off_q,
    input  logic [MULT_W-1:0] mult_q,
    input  logic              xo_buf_q,
    output logic              osc_en,
    output logic              osc_buf_en,
    output logic              sysclk_en,
    output logic              pll_en,
    output logic              pll_pwrdn,
    output logic              mult_bypass,
    output logic [MULT_W-1:0] mult_factor
);

    logic in_range;

    always_comb begin
        in_range    = mult_in_range(mult_q, MULT_MIN, MULT_MAX);
        osc_en      = pin_sel;
        osc_buf_en  = pin_sel && xo_buf_q;
        sysclk_en   = !clk_off_q;
        pll_en      = in_range;
        pll_pwrdn   = !in_range;
        mult_bypass = !in_range;
        mult_factor = in_range ? mult_q : MULT_W'(1);
    end

endmodule

// File: rtl/clkm_lock_fsm.sv
module clkm_lock_fsm
    import clkm_pkg::*;
#(
    parameter int LOCK_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic apply,
    input  logic restart_req,
    input  logic bypass_req,
    input  logic clk_off_q,
    output logic clk_valid
);

    localparam int CNT_W = (LOCK_CYCLES > 1) ? $clog2(LOCK_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(LOCK_CYCLES - 1);

    lock_state_e      state, nxt;
    logic [CNT_W-1:0] cnt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_UNSET;
        else        state <= nxt;
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_UNSET, ST_VALID: begin
                if (restart_req)  nxt = ST_LOCKING;   // T_START
                else if (apply)   nxt = ST_VALID;     // T_SETTLE
            end
            ST_LOCKING: begin
                if (restart_req)       nxt = ST_LOCKING; // T_RELOAD, wins over expiry (R10)
                else if (bypass_req)   nxt = ST_VALID;   // T_ABORT
                else if (cnt == '0)    nxt = ST_VALID;   // T_EXPIRE
            end
            default: nxt = ST_UNSET;
        endcase
    end

    // lock counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (restart_req)
            cnt <= CNT_LOAD;
        else if (state == ST_LOCKING && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    // outputs
    always_comb begin
        clk_valid = (state == ST_VALID) && !clk_off_q;
    end

endmodule

// File: rtl/clk_mode_ctrl.sv
module clk_mode_ctrl
    import clkm_pkg::*;
#(
    parameter int LOCK_CYCLES = 1000,
    parameter int MULT_MIN    = 4,
    parameter int MULT_MAX    = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_sel_pin,
    input  logic              cfg_apply,
    input  logic              cfg_clk_off,
    input  logic [MULT_W-1:0] cfg_mult,
    input  logic              cfg_xo_buf,
    output logic              osc_en,
    output logic              osc_buf_en,
    output logic              sysclk_en,
    output logic              pll_en,
    output logic              pll_pwrdn,
    output logic              mult_bypass,
    output logic [MULT_W-1:0] mult_factor,
    output logic              clk_valid
);

    logic              clk_off_q, xo_buf_q, restart_req, bypass_req;
    logic [MULT_W-1:0] mult_q;

    clkm_cfg_regs #(.MULT_MIN(MULT_MIN), .MULT_MAX(MULT_MAX)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .apply       (cfg_apply),
        .clk_off_in  (cfg_clk_off),
        .mult_in     (cfg_mult),
        .xo_buf_in   (cfg_xo_buf),
        .clk_off_q   (clk_off_q),
        .mult_q      (mult_q),
        .xo_buf_q    (xo_buf_q),
        .restart_req (restart_req),
        .bypass_req  (bypass_req)
    );

    clkm_decode #(.MULT_MIN(MULT_MIN), .MULT_MAX(MULT_MAX)) u_dec (
        .pin_sel     (mode_sel_pin),
        .clk_off_q   (clk_off_q),
        .mult_q      (mult_q),
        .xo_buf_q    (xo_buf_q),
        .osc_en      (osc_en),
        .osc_buf_en  (osc_buf_en),
        .sysclk_en   (sysclk_en),
        .pll_en      (pll_en),
        .pll_pwrdn   (pll_pwrdn),
        .mult_bypass (mult_bypass),
        .mult_factor (mult_factor)
    );

    clkm_lock_fsm #(.LOCK_CYCLES(LOCK_CYCLES)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .apply       (cfg_apply),
        .restart_req (restart_req),
        .bypass_req  (bypass_req),
        .clk_off_q   (clk_off_q),
        .clk_valid   (clk_valid)
    );

endmodule

// File: rtl/clk_mode_ctrl_checker.sv
module clk_mode_ctrl_checker
    import clkm_pkg::*;
#(
    parameter int MULT_MIN = 4,
    parameter int MULT_MAX = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mode_sel_pin,
    input logic              cfg_apply,
    input logic              cfg_clk_off,
    input logic [MULT_W-1:0] cfg_mult,
    input logic              osc_en,
    input logic              osc_buf_en,
    input logic              sysclk_en,
    input logic              mult_bypass,
    input logic [MULT_W-1:0] mult_factor,
    input logic              clk_valid
);

    logic new_in;
    assign new_in = mult_in_range(cfg_mult, MULT_MIN, MULT_MAX);

    a_r2_hold_without_commit: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_apply |=> ($stable(mult_factor) && $stable(sysclk_en)));

    a_r4_bypass_factor_one: assert property (@(posedge clk) disable iff (!rst_n)
        mult_bypass |-> (mult_factor == MULT_W'(1)));

    a_r5_pin_low_osc_off: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_sel_pin |-> (!osc_en && !osc_buf_en));

    a_r6_valid_needs_clock: assert property (@(posedge clk) disable iff (!rst_n)
        clk_valid |-> sysclk_en);

    a_r7_change_blocks_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_apply && new_in && (mult_bypass || cfg_mult != mult_factor)) |=> !clk_valid);

    a_r9_bypass_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_apply && !new_in && !cfg_clk_off) |=> clk_valid);

endmodule

bind clk_mode_ctrl clk_mode_ctrl_checker #(.MULT_MIN(MULT_MIN), .MULT_MAX(MULT_MAX)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_sel_pin (mode_sel_pin),
    .cfg_apply    (cfg_apply),
    .cfg_clk_off  (cfg_clk_off),
    .cfg_mult     (cfg_mult),
    .osc_en       (osc_en),
    .osc_buf_en   (osc_buf_en),
    .sysclk_en    (sysclk_en),
    .mult_bypass  (mult_bypass),
    .mult_factor  (mult_factor),
    .clk_valid    (clk_valid)
);

// File: tb/tb_clk_mode_ctrl.sv
module tb_clk_mode_ctrl;

    localparam int N = 8;     // lock cycles used on the bench
    localparam int NV = 7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_sel_pin = 1'b0;
    logic       cfg_apply = 1'b0;
    logic       cfg_clk_off = 1'b0;
    logic [4:0] cfg_mult = '0;
    logic       cfg_xo_buf = 1'b0;
    logic       osc_en, osc_buf_en, sysclk_en, pll_en, pll_pwrdn, mult_bypass, clk_valid;
    logic [4:0] mult_factor;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    clk_mode_ctrl #(.LOCK_CYCLES(N)) dut (
        .clk(clk), .rst_n(rst_n), .mode_sel_pin(mode_sel_pin), .cfg_apply(cfg_apply),
        .cfg_clk_off(cfg_clk_off), .cfg_mult(cfg_mult), .cfg_xo_buf(cfg_xo_buf),
        .osc_en(osc_en), .osc_buf_en(osc_buf_en), .sysclk_en(sysclk_en), .pll_en(pll_en),
        .pll_pwrdn(pll_pwrdn), .mult_bypass(mult_bypass), .mult_factor(mult_factor),
        .clk_valid(clk_valid)
    );

    // {pin, off, xo, mult[4:0], exp osc, buf, sys, pll, factor[4:0]}
    localparam logic [16:0] VEC [NV] = '{
        {1'b1, 1'b0, 1'b1, 5'd4,  1'b1, 1'b1, 1'b1, 1'b1, 5'd4 },
        {1'b1, 1'b0, 1'b0, 5'd20, 1'b1, 1'b0, 1'b1, 1'b1, 5'd20},
        {1'b0, 1'b0, 1'b1, 5'd3,  1'b0, 1'b0, 1'b1, 1'b0, 5'd1 },
        {1'b0, 1'b1, 1'b1, 5'd21, 1'b0, 1'b0, 1'b0, 1'b0, 5'd1 },
        {1'b1, 1'b1, 1'b1, 5'd0,  1'b1, 1'b1, 1'b0, 1'b0, 5'd1 },
        {1'b1, 1'b0, 1'b1, 5'd31, 1'b1, 1'b1, 1'b1, 1'b0, 5'd1 },
        {1'b0, 1'b0, 1'b0, 5'd12, 1'b0, 1'b0, 1'b1, 1'b1, 5'd12}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // called right after a negedge; commit is sampled at the next posedge
    task automatic commit(input logic off, input logic [4:0] m, input logic xo);
        cfg_clk_off = off;
        cfg_mult    = m;
        cfg_xo_buf  = xo;
        cfg_apply   = 1'b1;
        @(negedge clk);
        cfg_apply   = 1'b0;
    endtask

    // after commit return: low now and for N-1 more samples, then high
    task automatic expect_lock(input string req);
        chk(req, int'(clk_valid), 0);
        for (int i = 1; i < N; i++) begin
            @(negedge clk);
            chk(req, int'(clk_valid), 0);
        end
        @(negedge clk);
        chk(req, int'(clk_valid), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 clk_valid", int'(clk_valid), 0);
        chk("R1 bypass", int'(mult_bypass), 1);
        chk("R1 pwrdn", int'(pll_pwrdn), 1);
        chk("R1 pll_en", int'(pll_en), 0);
        chk("R1 factor", int'(mult_factor), 1);
        chk("R1 sysclk", int'(sysclk_en), 1);
        chk("R1 buf", int'(osc_buf_en), 0);

        // table walk: R3 R4 R5 R6
        for (int v = 0; v < NV; v++) begin
            mode_sel_pin = VEC[v][16];
            commit(VEC[v][15], VEC[v][13:9], VEC[v][14]);
            repeat (N + 1) @(negedge clk);
            chk("R5 osc_en", int'(osc_en), int'(VEC[v][8]));
            chk("R5 osc_buf_en", int'(osc_buf_en), int'(VEC[v][7]));
            chk("R6 sysclk_en", int'(sysclk_en), int'(VEC[v][6]));
            chk("R3 pll_en", int'(pll_en), int'(VEC[v][5]));
            chk("R4 pll_pwrdn", int'(pll_pwrdn), int'(!VEC[v][5]));
            chk("R4 bypass", int'(mult_bypass), int'(!VEC[v][5]));
            chk("R3 factor", int'(mult_factor), int'(VEC[v][4:0]));
            chk("R6 clk_valid", int'(clk_valid), int'(VEC[v][6]));
        end
        // now factor 12, valid, pin 0

        // R2: staged inputs without commit are ignored
        cfg_mult = 5'd7; cfg_clk_off = 1'b1; cfg_xo_buf = 1'b1;
        repeat (3) @(negedge clk);
        chk("R2 factor", int'(mult_factor), 12);
        chk("R2 sysclk", int'(sysclk_en), 1);
        chk("R2 valid", int'(clk_valid), 1);

        // R5: pin live toggle
        mode_sel_pin = 1'b1; #1;
        chk("R5 osc follows pin", int'(osc_en), 1);
        chk("R5 buf off (xo bit 0)", int'(osc_buf_en), 0);
        @(negedge clk);

        // R7: from bypass into an enabled factor
        commit(1'b0, 5'd0, 1'b0);
        chk("R9 bypass valid", int'(clk_valid), 1);
        commit(1'b0, 5'd9, 1'b0);
        expect_lock("R7 lock from bypass");

        // R8: same factor from ST_VALID
        commit(1'b0, 5'd9, 1'b0);
        chk("R8 same factor stays valid", int'(clk_valid), 1);

        // R8: same factor during lock keeps original expiry
        commit(1'b0, 5'd10, 1'b0);
        repeat (3) @(negedge clk);
        commit(1'b0, 5'd10, 1'b0);
        for (int i = 0; i < N - 5; i++) begin
            @(negedge clk);
            chk("R8 still locking", int'(clk_valid), 0);
        end
        @(negedge clk);
        chk("R8 original expiry", int'(clk_valid), 1);

        // R9: bypass aborts a running lock
        commit(1'b0, 5'd5, 1'b0);
        repeat (2) @(negedge clk);
        chk("R7 locking", int'(clk_valid), 0);
        commit(1'b0, 5'd25, 1'b0);
        chk("R9 abort to valid", int'(clk_valid), 1);
        chk("R9 factor", int'(mult_factor), 1);

        // R10: new factor committed on the expiry edge
        commit(1'b0, 5'd8, 1'b0);
        repeat (N - 1) @(negedge clk);
        commit(1'b0, 5'd11, 1'b0);
        expect_lock("R10 restart wins");
        chk("R10 factor", int'(mult_factor), 11);

        // R6: gating off keeps oscillator, drops valid
        commit(1'b1, 5'd11, 1'b1);
        chk("R6 sysclk off", int'(sysclk_en), 0);
        chk("R6 valid off", int'(clk_valid), 0);
        chk("R6 osc kept", int'(osc_en), 1);
        chk("R5 buf on", int'(osc_buf_en), 1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule